// File: doc/BRIEF.md
# Reaction Time Measurement Controller

This block runs one round of a reaction test. A start pulse opens a round: the millisecond result is cleared to zero and the cue output is held dark for a pseudo-random wait. When the wait ends, the cue lights and a binary millisecond counter begins to run. Its value is visible live on the result port. The first react pulse while the cue is lit stops the counter, turns the cue off and raises a one-cycle capture strobe, so that a downstream store can keep the result.

The wait is drawn from a free-running 16-bit linear feedback shift register, sampled when start arrives. The drawn value is clamped to a whole number of wait units. With the default of 100 ms per unit, the wait is always between 1 s and 10 s. A clock divider derived from the clock frequency parameter produces the millisecond tick. Both start and react arrive already debounced and one clock wide. Decimal conversion and display driving happen elsewhere.

Top module: `reaction_timer`

## Requirements
- R1: After reset, `elapsed_ms` is 0, `cue_led` is 0 and `result_valid` is 0.
- R2: A `start_pulse` in any state makes `elapsed_ms` 0 and `cue_led` 0 from the next cycle, and begins a new wait, including when a round is already running.
- R3: `cue_led` rises exactly D milliseconds after the clock edge that samples `start_pulse`, that is D*CLK_HZ/1000 cycles. D is a multiple of UNIT_MS and lies between MIN_UNITS*UNIT_MS and MAX_UNITS*UNIT_MS.
- R4: The number of wait units is taken from a free-running pseudo-random sequence at each start, so successive rounds do not all wait the same time.
- R5: While `cue_led` is 1, `elapsed_ms` is an unsigned binary count that starts at 0 when the cue rises and increases by one every millisecond. t cycles after the cue edge it reads floor(t*1000/CLK_HZ).
- R6: A `react_pulse` sampled while `cue_led` is 1 clears `cue_led` and freezes `elapsed_ms` at the value it showed in the cycle of the press.
- R7: A `react_pulse` during the wait has no effect. `elapsed_ms` stays 0, no strobe appears, and the cue still rises on the schedule of R3.
- R8: `elapsed_ms` saturates at 255 (all ones) and holds there with the cue still lit until react or start.
- R9: `result_valid` is 1 for exactly one cycle, the cycle after a react accepted under R6, and at no other time.
- R10: Outside a running count (idle or stopped), `react_pulse` leaves `elapsed_ms` unchanged and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_pulse | input | 1 | One-cycle request to begin a new round |
| react_pulse | input | 1 | One-cycle user response |
| cue_led | output | 1 | High while the millisecond count runs |
| elapsed_ms | output | CNT_W (8) | Binary milliseconds since the cue, live or frozen |
| result_valid | output | 1 | One-cycle strobe when a round ends on a valid react |

## Verification
The assertions take both inputs to be synchronous to `clk` and one cycle wide. They also assume that start and react never arrive in the same cycle; start wins if they do, and no check covers that case. The bench drives every pulse for exactly one cycle on the falling edge and never raises both together. It places early reacts well inside the shortest possible wait, so they always land while the block is still waiting. Hold times before the react press are drawn from a seeded `$urandom`. Directed rounds add an immediate press, presses on either side of a tick, saturation, and a restart in mid-count.

// File: rtl/rt_pkg.sv
// Shared types for the reaction timer.
// Assumes: nothing; included first in compile order.
package rt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } rt_state_t;
endpackage

// File: rtl/rt_lfsr.sv
// Free-running Galois shift register used as a pseudo-random source.
// Assumes: SEED is non-zero; the register steps every clock and is never stalled.
module rt_lfsr #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   TAPS = 'hB400,
    parameter logic [W-1:0]   SEED = 'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    // Advance the sequence one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= SEED;
        else if (value[0])
            value <= (value >> 1) ^ TAPS;
        else
            value <= value >> 1;
    end
endmodule

// File: rtl/rt_tick_div.sv
// Divides the clock down to a one-cycle tick every DIV cycles.
// Assumes: DIV >= 1; restart realigns the phase so the first tick follows DIV cycles later.
module rt_tick_div #(
    parameter int DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    // Count cycles within one tick period, wrapping at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + CW'(1);
    end

    assign tick = (phase == LAST);
endmodule

// File: rtl/rt_delay_pick.sv
// Turns a raw random field into a clamped wait length in milliseconds.
// Assumes: MIN_UNITS <= MAX_UNITS and both fit in RAW_W bits.
module rt_delay_pick #(
    parameter int RAW_W     = 7,
    parameter int WAIT_W    = 14,
    parameter int UNIT_MS   = 100,
    parameter int MIN_UNITS = 10,
    parameter int MAX_UNITS = 100
) (
    input  logic [RAW_W-1:0]  raw,
    output logic [WAIT_W-1:0] wait_ms
);
    localparam logic [RAW_W-1:0]  LO     = RAW_W'(MIN_UNITS);
    localparam logic [RAW_W-1:0]  HI     = RAW_W'(MAX_UNITS);
    localparam logic [WAIT_W-1:0] UNIT_V = WAIT_W'(UNIT_MS);

    logic [RAW_W-1:0] units;

    // Clamp the unit count into range, then scale it to milliseconds.
    always_comb begin
        if (raw < LO)
            units = LO;
        else if (raw > HI)
            units = HI;
        else
            units = raw;
        wait_ms = WAIT_W'(units) * UNIT_V;
    end
endmodule

// File: rtl/reaction_timer.sv
// Reaction round sequencer: random wait, cue, stoppable millisecond count, capture strobe.
// Assumes: start_pulse and react_pulse are synchronous, one cycle wide and debounced;
// CLK_HZ is a multiple of 1000; start has priority over react.
module reaction_timer #(
    parameter int CLK_HZ    = 100_000_000,
    parameter int UNIT_MS   = 100,
    parameter int MIN_UNITS = 10,
    parameter int MAX_UNITS = 100,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_pulse,
    input  logic             react_pulse,
    output logic             cue_led,
    output logic [CNT_W-1:0] elapsed_ms,
    output logic             result_valid
);
    import rt_pkg::*;

    localparam int               CYC_PER_MS = CLK_HZ / 1000;
    localparam int               RAW_W      = $clog2(MAX_UNITS + 1);
    localparam int               WAIT_W     = $clog2(MAX_UNITS * UNIT_MS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
    localparam logic [WAIT_W-1:0] MIN_MS    = WAIT_W'(MIN_UNITS * UNIT_MS);
    localparam logic [WAIT_W-1:0] MAX_MS    = WAIT_W'(MAX_UNITS * UNIT_MS);

    rt_state_t         state;
    logic [15:0]       rnd;
    logic              ms_tick;
    logic [WAIT_W-1:0] pick_ms;
    logic [WAIT_W-1:0] wait_left;

    rt_lfsr #(.W(16)) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    rt_tick_div #(.DIV(CYC_PER_MS)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_pulse),
        .tick    (ms_tick)
    );

    rt_delay_pick #(
        .RAW_W     (RAW_W),
        .WAIT_W    (WAIT_W),
        .UNIT_MS   (UNIT_MS),
        .MIN_UNITS (MIN_UNITS),
        .MAX_UNITS (MAX_UNITS)
    ) i_pick (
        .raw     (rnd[RAW_W-1:0]),
        .wait_ms (pick_ms)
    );

    // Round sequencing: wait countdown, running count, stop and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            wait_left    <= '0;
            elapsed_ms   <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            if (start_pulse) begin
                state      <= ST_WAIT;
                wait_left  <= pick_ms;
                elapsed_ms <= '0;
            end else begin
                case (state)
                    ST_WAIT: begin
                        if (ms_tick) begin
                            if (wait_left <= WAIT_W'(1))
                                state <= ST_RUN;
                            else
                                wait_left <= wait_left - WAIT_W'(1);
                        end
                    end
                    ST_RUN: begin
                        if (react_pulse) begin
                            state        <= ST_HOLD;
                            result_valid <= 1'b1;
                        end else if (ms_tick && elapsed_ms != CNT_MAX) begin
                            elapsed_ms <= elapsed_ms + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cue_led = (state == ST_RUN);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> (elapsed_ms == '0 && !cue_led)); // R2
    AST_WAIT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> (wait_left >= MIN_MS && wait_left <= MAX_MS)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !start_pulse |=> (elapsed_ms == $past(elapsed_ms) ||
                          elapsed_ms == $past(elapsed_ms) + CNT_W'(1))); // R5
    AST_EARLY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && react_pulse && !start_pulse) |=> (!result_valid && elapsed_ms == '0)); // R7
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed_ms == CNT_MAX && !start_pulse) |=> (elapsed_ms == CNT_MAX)); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R9
    AST_STROBE_AFTER_CUE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(cue_led) && !cue_led)); // R9
    AST_DARK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cue_led && !start_pulse) |=> (elapsed_ms == $past(elapsed_ms) && !result_valid)); // R10
endmodule

// File: tb/test_reaction_timer.sv
module test_reaction_timer;
    localparam int CPM   = 4;
    localparam int UNIT  = 2;
    localparam int MINU  = 10;
    localparam int MAXU  = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       react = 1'b0;
    logic       cue;
    logic [7:0] elapsed;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;
    int d_min = 1 << 30;
    int d_max = 0;

    reaction_timer #(
        .CLK_HZ(CPM * 1000), .UNIT_MS(UNIT), .MIN_UNITS(MINU), .MAX_UNITS(MAXU), .CNT_W(8)
    ) i_reaction_timer (
        .clk(clk), .rst_n(rst_n), .start_pulse(start), .react_pulse(react),
        .cue_led(cue), .elapsed_ms(elapsed), .result_valid(done)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_count(input int t);
        int v = t / CPM;
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int delay_ok(input int cyc);
        return (cyc % (UNIT * CPM) == 0 && cyc >= MINU * UNIT * CPM &&
                cyc <= MAXU * UNIT * CPM) ? 1 : 0;
    endfunction

    // Pulse start and follow the wait until the cue lights; optional early react.
    task automatic begin_round(input int early);
        int j = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R2 count cleared", int'(elapsed), 0);
        check("R2 cue dark", int'(cue), 0);
        while (!cue && j < 2000) begin
            react = (early != 0 && j == early);
            @(negedge clk);
            react = 1'b0;
            j++;
            if (!cue) check("R7 waiting untouched", int'({done, elapsed}), 0);
        end
        check("R3 delay on schedule", delay_ok(j), 1);
        if (j < d_min) d_min = j;
        if (j > d_max) d_max = j;
    endtask

    // Let the count run hold_k cycles past the cue, then press react and check the result.
    task automatic finish_round(input int hold_k);
        int expv = exp_count(hold_k);
        for (int t = 0; t < hold_k; t++) begin
            if (exp_count(t) == 255) check("R8 saturated", int'(elapsed), 255);
            else check("R5 live count", int'(elapsed), exp_count(t));
            check("R5 cue lit", int'(cue), 1);
            @(negedge clk);
        end
        check("R5 count at press", int'(elapsed), expv);
        react = 1'b1;
        @(negedge clk); react = 1'b0;
        check("R6 frozen result", int'(elapsed), expv);
        check("R6 cue off", int'(cue), 0);
        check("R9 strobe", int'(done), 1);
        @(negedge clk);
        check("R9 strobe one cycle", int'(done), 0);
        react = 1'b1;
        @(negedge clk); react = 1'b0;
        @(negedge clk);
        check("R10 late react ignored", int'(elapsed), expv);
        check("R10 no strobe", int'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count", int'(elapsed), 0);
        check("R1 cue", int'(cue), 0);
        check("R1 strobe", int'(done), 0);
        react = 1'b1;
        @(negedge clk); react = 1'b0;
        @(negedge clk);
        check("R10 idle react", int'({done, elapsed}), 0);

        begin_round(0);  finish_round(0);
        begin_round(5);  finish_round(3);
        begin_round(20); finish_round(4);
        begin_round(0);  finish_round(255 * CPM + 40);

        // Restart while counting: the next start must clear at once.
        begin_round(0);
        repeat (30) @(negedge clk);
        begin_round(0); finish_round(17);

        for (int r = 0; r < 20; r++) begin
            int early = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, 40)) : 0;
            begin_round(early);
            finish_round(int'($urandom_range(0, 300)));
        end

        check("R4 delays vary", (d_min != d_max) ? 1 : 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule